// File: doc/BRIEF.md
# Random Generator Command Front-End

This block is the register-mapped control side of a random number peripheral. A host on a simple 32-bit bus (one-cycle writes, combinational reads) writes commands into a control register. A sequencer runs each command for a fixed number of clock cycles. It reports generate-busy and reseed-busy in the status register and fills a bank of 32-bit output words only when a generate finishes. A 32-bit Galois LFSR stands in for the real entropy core. It is loaded from the `seed_i` input when a reseed completes, and each generate steps it to produce fresh words.

Three completion events set sticky interrupt-status bits, which software clears by writing ones: data ready, seed done and generator lockup. Each bit has its own enable, and a global enable gates the single interrupt line. Two optional triggers start a reseed with no host command. The first counts completed generates against a programmed reload value. The second is a free-running age timer. Either trigger leaves a pending request that runs the next time the sequencer is idle. If a reseed loads an all-zero seed, the generator is locked up. It then refuses generates until a later reseed loads a nonzero value.

Top module: `rnd_frontend`

## Requirements
- R1: After reset, every register reads 0, the status register reads 0, `irq_o` is low and the LFSR holds RESET_STATE (1). In any cycle without a read (`bus_sel_i` low or `bus_we_i` high), `bus_rdata_o` is 0.
- R2: A write of 1 to the control register (offset 0x00), made while the block is idle, starts a generate. Status bit 30 reads 1 for exactly GEN_CYCLES cycles, starting the cycle after the write. On the clock edge that clears bit 30, the output words are refreshed and interrupt-status bit 0 is set.
- R3: A write of 2 to the control register while idle starts a reseed. Status bit 31 reads 1 for exactly SEED_CYCLES cycles. When it completes, the LFSR is loaded with `seed_i` as sampled on the completing edge, status bit 9 (seeded) becomes 1 exactly when that seed is nonzero, and interrupt-status bit 1 is set.
- R4: A control write takes effect only when both busy bits are clear and no automatic reseed is pending. Writes at other times are dropped. A value of 0, or any value other than 1 and 2, changes nothing.
- R5: Let s0 be the LFSR state and s(k+1) = (s(k) >> 1) XOR (s(k)[0] ? 0x80200003 : 0). A generate writes s(i+1) into word i, which is read at offset 0x20 + 4*i. With mode bit 3 set, words 0 to 7 are written and the LFSR moves to s8. With mode bit 3 clear, only words 0 to 3 are written, words 4 to 7 keep their old values and the LFSR moves to s4. The words change at no other time.
- R6: Mode register (offset 0x08) bit 3 and secure-mode register (offset 0x0C) bit 8 are writable and read back. Status bit 3 mirrors mode bit 3, and status bit 8 mirrors secure-mode bit 8.
- R7: Interrupt status (offset 0x14) sets bit 0 on generate completion, bit 1 on reseed completion and bit 4 on a lockup event. Writing 1 to a bit clears it. An event in the same cycle as a clear wins.
- R8: Interrupt enable (offset 0x10) keeps bits 0, 1, 4 and 31. `irq_o` = bit 31 AND (OR over bits 0, 1 and 4 of interrupt status ANDed with the enable).
- R9: A write of N to offset 0x60 loads both a reload register and a counter. With N nonzero, every completed generate decrements the counter. The generate that finds the counter at 1 reloads it to N and raises a pending reseed. The pending reseed starts in the first idle cycle after that. N = 0 disables this trigger.
- R10: A write of N to offset 0x64 loads the age timer. With N nonzero, the timer decrements every cycle and raises a pending reseed on the N-th edge after the write, then every N edges after that. N = 0 disables it.
- R11: A reseed that loads 0 sets interrupt-status bit 4 and leaves the seeded bit clear. While the LFSR is zero, generate commands are dropped, with no busy bit and no word change. A later reseed with a nonzero seed clears the condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Bus access this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| seed_i | input | 32 | Seed value taken when a reseed completes |
| irq_o | output | 1 | Interrupt request |

## Verification
A behavioural model in the bench follows every command, counter and flag cycle by cycle. Each read and the interrupt line are compared against it. Generates are run in both the eight-word and four-word modes, which separates a refresh of all eight words from a refresh of only the lower four with the upper four left stale. Commands are also issued while the block is busy and with unused codes, which shows whether the sequencer restarts or drops them. The request-count and age-timer triggers are run, alone and against host commands, to check the pending-reseed priority. A zero seed followed by a nonzero one exercises lockup entry, the refusal of generates, and recovery.

// File: rtl/rnd_pkg.sv
`timescale 1ns/1ps
package rnd_pkg;
  // register offsets
  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_STAT  = 8'h04;
  localparam logic [7:0] OFS_MODE  = 8'h08;
  localparam logic [7:0] OFS_SMODE = 8'h0C;
  localparam logic [7:0] OFS_IE    = 8'h10;
  localparam logic [7:0] OFS_IST   = 8'h14;
  localparam logic [7:0] OFS_WORD0 = 8'h20;
  localparam logic [7:0] OFS_AREQ  = 8'h60;
  localparam logic [7:0] OFS_AAGE  = 8'h64;

  typedef enum logic [1:0] {CMD_NOP = 2'd0, CMD_GEN = 2'd1, CMD_SEED = 2'd2} cmd_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_GEN, SQ_SEED} sq_e;

  // one Galois shift of the stand-in generator
  function automatic logic [31:0] lfsr_step(input logic [31:0] s, input logic [31:0] taps);
    return (s >> 1) ^ (s[0] ? taps : 32'h0);
  endfunction

  // a countdown reaching its last tick
  function automatic logic cnt_last(input logic [15:0] c);
    return c <= 16'd1;
  endfunction
endpackage

// File: rtl/rnd_seq.sv
`timescale 1ns/1ps
module rnd_seq import rnd_pkg::*; #(
  parameter int GEN_CYCLES  = 8,
  parameter int SEED_CYCLES = 12,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr_i,
  input  logic [31:0]      ctrl_data_i,
  input  logic             locked_i,
  input  logic             areq_wr_i,
  input  logic             aage_wr_i,
  input  logic [CNT_W-1:0] cfg_data_i,
  output logic             gen_busy_o,
  output logic             seed_busy_o,
  output logic             gen_done_o,
  output logic             seed_done_o,
  output logic [CNT_W-1:0] areq_o,
  output logic [CNT_W-1:0] aage_o
);
  localparam int LAT_MAX = (GEN_CYCLES > SEED_CYCLES) ? GEN_CYCLES : SEED_CYCLES;
  localparam int LAT_W   = $clog2(LAT_MAX + 1);
  localparam logic [LAT_W-1:0] GEN_LOAD  = LAT_W'(GEN_CYCLES - 1);
  localparam logic [LAT_W-1:0] SEED_LOAD = LAT_W'(SEED_CYCLES - 1);

  sq_e              state_q;
  logic [LAT_W-1:0] lat_q;
  logic             pend_q;
  logic [CNT_W-1:0] areq_q, aage_q, reqcnt_q, agecnt_q;

  logic idle, start_auto, host_cmd, start_gen, start_seed, req_exp, age_exp;

  always_comb begin
    idle        = (state_q == SQ_IDLE);
    start_auto  = idle & pend_q;
    host_cmd    = ctrl_wr_i & idle & ~pend_q;
    start_gen   = host_cmd & (ctrl_data_i == 32'(CMD_GEN)) & ~locked_i;
    start_seed  = start_auto | (host_cmd & (ctrl_data_i == 32'(CMD_SEED)));
    gen_done_o  = (state_q == SQ_GEN)  && (lat_q == '0);
    seed_done_o = (state_q == SQ_SEED) && (lat_q == '0);
    req_exp     = ~areq_wr_i & gen_done_o & (areq_q != '0) & cnt_last(16'(reqcnt_q));
    age_exp     = ~aage_wr_i & (aage_q != '0) & cnt_last(16'(agecnt_q));
  end

  assign gen_busy_o  = (state_q == SQ_GEN);
  assign seed_busy_o = (state_q == SQ_SEED);
  assign areq_o      = areq_q;
  assign aage_o      = aage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      lat_q   <= '0;
    end else if (start_gen) begin
      state_q <= SQ_GEN;
      lat_q   <= GEN_LOAD;
    end else if (start_seed) begin
      state_q <= SQ_SEED;
      lat_q   <= SEED_LOAD;
    end else if (gen_done_o || seed_done_o) begin
      state_q <= SQ_IDLE;
    end else if (!idle) begin
      lat_q <= lat_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      areq_q <= '0; reqcnt_q <= '0;
    end else if (areq_wr_i) begin
      areq_q <= cfg_data_i; reqcnt_q <= cfg_data_i;
    end else if (gen_done_o && areq_q != '0) begin
      reqcnt_q <= req_exp ? areq_q : reqcnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aage_q <= '0; agecnt_q <= '0;
    end else if (aage_wr_i) begin
      aage_q <= cfg_data_i; agecnt_q <= cfg_data_i;
    end else if (aage_q != '0) begin
      agecnt_q <= age_exp ? aage_q : agecnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= req_exp | age_exp | (pend_q & ~start_auto);
  end

  // R2
  gen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_GEN && lat_q != '0) |=> state_q == SQ_GEN);
  // R4
  busy_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && lat_q != '0) |=> lat_q == $past(lat_q) - 1'b1);
  // R9
  pend_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !req_exp && !age_exp) |=> !pend_q);
  // R10
  age_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aage_q != '0) |-> (agecnt_q <= aage_q));
endmodule

// File: rtl/rnd_gen.sv
`timescale 1ns/1ps
module rnd_gen import rnd_pkg::*; #(
  parameter int          NWORDS      = 8,
  parameter logic [31:0] TAPS        = 32'h80200003,
  parameter logic [31:0] RESET_STATE = 32'h00000001
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  gen_done_i,
  input  logic                  seed_done_i,
  input  logic                  wide_i,
  input  logic [31:0]           seed_i,
  output logic [NWORDS*32-1:0]  words_o,
  output logic                  seeded_o,
  output logic                  locked_o,
  output logic                  lock_evt_o
);
  localparam int HALF = NWORDS / 2;

  logic [31:0] state_q;
  logic        seeded_q;
  logic [31:0] chain [NWORDS+1];

  always_comb begin
    chain[0] = state_q;
    for (int i = 0; i < NWORDS; i++) chain[i+1] = lfsr_step(chain[i], TAPS);
  end

  generate
    for (genvar w = 0; w < NWORDS; w++) begin : g_word
      localparam bit IN_LOW = (w < HALF);
      logic [31:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else if (gen_done_i && (wide_i || IN_LOW)) word_q <= chain[w+1];
      end
      assign words_o[w*32 +: 32] = word_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= RESET_STATE;
      seeded_q <= 1'b0;
    end else if (seed_done_i) begin
      state_q  <= seed_i;
      seeded_q <= (seed_i != '0);
    end else if (gen_done_i) begin
      state_q  <= wide_i ? chain[NWORDS] : chain[HALF];
    end
  end

  assign seeded_o   = seeded_q;
  assign locked_o   = (state_q == '0);
  assign lock_evt_o = seed_done_i && (seed_i == '0);

  // R5
  words_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_done_i |=> $stable(words_o));
  // R5
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_done_i && !wide_i) |=> $stable(words_o[NWORDS*32-1:HALF*32]));
  // R11
  lock_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == '0 && !seed_done_i) |=> state_q == '0);
endmodule

// File: rtl/rnd_irq.sv
`timescale 1ns/1ps
module rnd_irq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ie_wr_i,
  input  logic        ist_wr_i,
  input  logic [31:0] wdata_i,
  input  logic        ev_rdy_i,
  input  logic        ev_seed_i,
  input  logic        ev_lock_i,
  output logic [31:0] ie_o,
  output logic [31:0] ist_o,
  output logic        irq_o
);
  localparam int B_RDY  = 0;
  localparam int B_SEED = 1;
  localparam int B_LOCK = 4;
  localparam int B_GLB  = 31;
  localparam logic [31:0] SRC_MASK = (32'd1 << B_RDY) | (32'd1 << B_SEED) | (32'd1 << B_LOCK);
  localparam logic [31:0] IE_MASK  = SRC_MASK | (32'd1 << B_GLB);

  logic [31:0] ie_q, ist_q, set_v, clr_v;

  always_comb begin
    set_v = '0;
    set_v[B_RDY]  = ev_rdy_i;
    set_v[B_SEED] = ev_seed_i;
    set_v[B_LOCK] = ev_lock_i;
    clr_v = ist_wr_i ? (wdata_i & SRC_MASK) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q  <= '0;
      ist_q <= '0;
    end else begin
      if (ie_wr_i) ie_q <= wdata_i & IE_MASK;
      ist_q <= (ist_q & ~clr_v) | set_v;
    end
  end

  assign ie_o  = ie_q;
  assign ist_o = ist_q;
  assign irq_o = ie_q[B_GLB] & (|(ist_q & ie_q & SRC_MASK));

  // R7
  rdy_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_rdy_i && !ist_q[B_RDY]) |=> !ist_q[B_RDY]);
  // R7
  w1c_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ist_wr_i && wdata_i[B_SEED] && !ev_seed_i) |=> !ist_q[B_SEED]);
  // R8
  irq_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_q[B_GLB] |-> !irq_o);
endmodule

// File: rtl/rnd_frontend.sv
`timescale 1ns/1ps
module rnd_frontend import rnd_pkg::*; #(
  parameter int          GEN_CYCLES  = 8,
  parameter int          SEED_CYCLES = 12,
  parameter int          NWORDS      = 8,
  parameter int          CNT_W       = 16,
  parameter logic [31:0] LFSR_TAPS   = 32'h80200003,
  parameter logic [31:0] RESET_STATE = 32'h00000001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel_i,
  input  logic        bus_we_i,
  input  logic [7:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  input  logic [31:0] seed_i,
  output logic        irq_o
);
  localparam int IDX_W    = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam int WORD_END = int'(OFS_WORD0) + 4 * NWORDS;

  logic wr, rd, mode_wr;
  logic wide_q, miss_q;
  logic gen_busy, seed_busy, gen_done, seed_done;
  logic seeded, locked, lock_evt;
  logic [CNT_W-1:0] areq, aage;
  logic [NWORDS*32-1:0] words;
  logic [31:0] word_arr [NWORDS];
  logic [31:0] ie, ist, status_w;
  logic [7:0]  word_off;

  assign wr      = bus_sel_i & bus_we_i;
  assign rd      = bus_sel_i & ~bus_we_i;
  assign mode_wr = wr && (bus_addr_i == OFS_MODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_q <= 1'b0;
      miss_q <= 1'b0;
    end else begin
      if (mode_wr) wide_q <= bus_wdata_i[3];
      if (wr && bus_addr_i == OFS_SMODE) miss_q <= bus_wdata_i[8];
    end
  end

  rnd_seq #(.GEN_CYCLES(GEN_CYCLES), .SEED_CYCLES(SEED_CYCLES), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr_i(wr && bus_addr_i == OFS_CTRL), .ctrl_data_i(bus_wdata_i),
    .locked_i(locked),
    .areq_wr_i(wr && bus_addr_i == OFS_AREQ), .aage_wr_i(wr && bus_addr_i == OFS_AAGE),
    .cfg_data_i(bus_wdata_i[CNT_W-1:0]),
    .gen_busy_o(gen_busy), .seed_busy_o(seed_busy),
    .gen_done_o(gen_done), .seed_done_o(seed_done),
    .areq_o(areq), .aage_o(aage)
  );

  rnd_gen #(.NWORDS(NWORDS), .TAPS(LFSR_TAPS), .RESET_STATE(RESET_STATE)) u_gen (
    .clk(clk), .rst_n(rst_n),
    .gen_done_i(gen_done), .seed_done_i(seed_done), .wide_i(wide_q), .seed_i(seed_i),
    .words_o(words), .seeded_o(seeded), .locked_o(locked), .lock_evt_o(lock_evt)
  );

  rnd_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .ie_wr_i(wr && bus_addr_i == OFS_IE), .ist_wr_i(wr && bus_addr_i == OFS_IST),
    .wdata_i(bus_wdata_i),
    .ev_rdy_i(gen_done), .ev_seed_i(seed_done), .ev_lock_i(lock_evt),
    .ie_o(ie), .ist_o(ist), .irq_o(irq_o)
  );

  generate
    for (genvar w = 0; w < NWORDS; w++) begin : g_arr
      assign word_arr[w] = words[w*32 +: 32];
    end
  endgenerate

  always_comb begin
    status_w     = '0;
    status_w[31] = seed_busy;
    status_w[30] = gen_busy;
    status_w[9]  = seeded;
    status_w[8]  = miss_q;
    status_w[3]  = wide_q;
  end

  assign word_off = bus_addr_i - OFS_WORD0;

  always_comb begin
    bus_rdata_o = '0;
    if (rd) begin
      case (bus_addr_i)
        OFS_STAT:  bus_rdata_o = status_w;
        OFS_MODE:  bus_rdata_o[3] = wide_q;
        OFS_SMODE: bus_rdata_o[8] = miss_q;
        OFS_IE:    bus_rdata_o = ie;
        OFS_IST:   bus_rdata_o = ist;
        OFS_AREQ:  bus_rdata_o = 32'(areq);
        OFS_AAGE:  bus_rdata_o = 32'(aage);
        default: begin
          if (int'(bus_addr_i) >= int'(OFS_WORD0) && int'(bus_addr_i) < WORD_END
              && bus_addr_i[1:0] == 2'b00)
            bus_rdata_o = word_arr[word_off[IDX_W+1:2]];
        end
      endcase
    end
  end

  // R6
  mode_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> status_w[3] == $past(bus_wdata_i[3]));
  // R2
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gen_busy && seed_busy));
endmodule

// File: tb/rnd_frontend_tb_top.sv
`timescale 1ns/1ps
module rnd_frontend_tb_top;
  localparam int GEN = 8;
  localparam int SEED = 12;
  localparam int NW = 8;
  localparam logic [31:0] TAPS = 32'h80200003;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic b_sel = 1'b0, b_we = 1'b0;
  logic [7:0] b_addr = 8'h0;
  logic [31:0] b_wdata = 32'h0, seed_in = 32'h0;
  logic [31:0] rdata;
  logic irq;

  int errors = 0, checks = 0, cyc = 0;
  string cur_tag = "R1";

  always #2.5 clk = ~clk;

  rnd_frontend #(.GEN_CYCLES(GEN), .SEED_CYCLES(SEED), .NWORDS(NW), .CNT_W(16),
                 .LFSR_TAPS(TAPS), .RESET_STATE(32'h1)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel_i(b_sel), .bus_we_i(b_we), .bus_addr_i(b_addr),
    .bus_wdata_i(b_wdata), .bus_rdata_o(rdata), .seed_i(seed_in), .irq_o(irq));

  // behavioural reference
  bit m_gen, m_seed, m_pend, m_seeded, m_wide, m_miss;
  int m_cnt, m_areq, m_reqcnt, m_aage, m_agecnt;
  logic [31:0] m_state, m_ie, m_ist;
  logic [31:0] m_words [NW];

  function automatic logic [31:0] next_val(input logic [31:0] s);
    bit low = s[0];
    logic [31:0] r = {1'b0, s[31:1]};
    if (low) r = r ^ TAPS;
    return r;
  endfunction

  task automatic model_reset();
    m_gen = 0; m_seed = 0; m_pend = 0; m_seeded = 0; m_wide = 0; m_miss = 0;
    m_cnt = 0; m_areq = 0; m_reqcnt = 0; m_aage = 0; m_agecnt = 0;
    m_state = 32'h1; m_ie = 0; m_ist = 0;
    for (int i = 0; i < NW; i++) m_words[i] = 0;
  endtask

  function automatic logic [31:0] model_read(input logic [7:0] a);
    logic [31:0] r = 0;
    case (a)
      8'h04: begin r[31] = m_seed; r[30] = m_gen; r[9] = m_seeded; r[8] = m_miss; r[3] = m_wide; end
      8'h08: r[3] = m_wide;
      8'h0C: r[8] = m_miss;
      8'h10: r = m_ie;
      8'h14: r = m_ist;
      8'h60: r = m_areq;
      8'h64: r = m_aage;
      default: if (a >= 8'h20 && a < 8'h20 + 4*NW && a[1:0] == 0) r = m_words[(a - 8'h20) / 4];
    endcase
    return r;
  endfunction

  task automatic model_step();
    bit wr, idle, st_auto, hcmd, st_gen, st_seed, gdone, sdone, rexp, aexp, lock_ev;
    logic [31:0] s;
    int n;
    wr = b_sel && b_we;
    idle = !m_gen && !m_seed;
    st_auto = idle && m_pend;
    hcmd = wr && b_addr == 8'h00 && idle && !m_pend;
    st_gen = hcmd && b_wdata == 1 && m_state != 0;
    st_seed = st_auto || (hcmd && b_wdata == 2);
    gdone = m_gen && m_cnt == 0;
    sdone = m_seed && m_cnt == 0;
    lock_ev = sdone && seed_in == 0;
    rexp = 0; aexp = 0;
    if (wr && b_addr == 8'h60) begin m_areq = b_wdata[15:0]; m_reqcnt = m_areq; end
    else if (gdone && m_areq != 0) begin
      if (m_reqcnt <= 1) begin rexp = 1; m_reqcnt = m_areq; end else m_reqcnt--;
    end
    if (wr && b_addr == 8'h64) begin m_aage = b_wdata[15:0]; m_agecnt = m_aage; end
    else if (m_aage != 0) begin
      if (m_agecnt <= 1) begin aexp = 1; m_agecnt = m_aage; end else m_agecnt--;
    end
    m_pend = rexp || aexp || (m_pend && !st_auto);
    if (gdone) begin
      n = m_wide ? NW : NW / 2;
      s = m_state;
      for (int i = 0; i < n; i++) begin s = next_val(s); m_words[i] = s; end
      m_state = s;
    end else if (sdone) begin
      m_state = seed_in; m_seeded = (seed_in != 0);
    end
    if (st_gen) begin m_gen = 1; m_cnt = GEN - 1; end
    else if (st_seed) begin m_seed = 1; m_cnt = SEED - 1; end
    else if (gdone) m_gen = 0;
    else if (sdone) m_seed = 0;
    else if (m_gen || m_seed) m_cnt--;
    if (wr && b_addr == 8'h14) m_ist = m_ist & ~(b_wdata & 32'h13);
    if (gdone) m_ist[0] = 1;
    if (sdone) m_ist[1] = 1;
    if (lock_ev) m_ist[4] = 1;
    if (wr && b_addr == 8'h10) m_ie = b_wdata & 32'h80000013;
    if (wr && b_addr == 8'h08) m_wide = b_wdata[3];
    if (wr && b_addr == 8'h0C) m_miss = b_wdata[8];
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s addr=%h got=%h exp=%h t=%0t", tag, b_addr, got, exp, $time);
    end
  endtask

  // compare mid-cycle, then advance the model to the next edge
  always @(negedge clk) begin
    if (!rst_n) model_reset();
    else begin
      check("R8", {31'b0, irq}, {31'b0, m_ie[31] && ((m_ist & m_ie & 32'h13) != 0)});
      if (b_sel && !b_we) check(cur_tag, rdata, model_read(b_addr));
      else check("R1", rdata, 32'h0);
      model_step();
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++; checks++;
      $display("FAIL R1 watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    b_sel = 1; b_we = 1; b_addr = a; b_wdata = d;
    @(posedge clk); #1;
    b_sel = 0; b_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    b_sel = 1; b_we = 0; b_addr = a; cur_tag = tag;
    @(posedge clk); #1;
    b_sel = 0; cur_tag = "R1";
  endtask

  task automatic poll(input int n, input string tag);
    for (int i = 0; i < n; i++) rd(8'h04, tag);
  endtask

  task automatic read_words(input string tag);
    for (int i = 0; i < NW; i++) rd(8'h20 + 8'(4*i), tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    // R1 reset values
    rd(8'h00, "R1"); rd(8'h04, "R1"); rd(8'h10, "R1"); rd(8'h14, "R1");
    rd(8'h60, "R1"); rd(8'h64, "R1"); read_words("R1");
    // R2 generate before first seed, eight-word mode
    wr(8'h08, 32'h8); rd(8'h08, "R6");
    wr(8'h00, 32'h1); poll(GEN + 2, "R2"); read_words("R5");
    // R4 commands while busy and unused codes
    wr(8'h00, 32'h1); wr(8'h00, 32'h2); poll(3, "R4"); poll(GEN, "R2");
    wr(8'h00, 32'h3); rd(8'h04, "R4"); wr(8'h00, 32'h0); rd(8'h04, "R4"); read_words("R4");
    // R3 reseed
    seed_in = 32'hC0DE_1234;
    wr(8'h00, 32'h2); poll(SEED + 2, "R3"); rd(8'h14, "R3");
    // R5 four-word mode keeps the upper words
    wr(8'h08, 32'h0); wr(8'h00, 32'h1); poll(GEN + 1, "R2"); read_words("R5");
    wr(8'h08, 32'h8); wr(8'h00, 32'h1); poll(GEN + 1, "R2"); read_words("R5");
    // R6 secure-mode mirror
    wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, "R6"); rd(8'h04, "R6");
    // R7 R8 enables and write-one-to-clear
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, "R8"); idle(2);
    wr(8'h14, 32'h1); rd(8'h14, "R7"); idle(1);
    wr(8'h10, 32'h0000_0013); idle(2);
    wr(8'h10, 32'h8000_0010); idle(2);
    wr(8'h14, 32'h2); rd(8'h14, "R7");
    wr(8'h10, 32'h8000_0001); wr(8'h00, 32'h1);
    for (int i = 0; i < GEN - 1; i++) idle(1);
    wr(8'h14, 32'h1); rd(8'h14, "R7"); idle(2);
    wr(8'h14, 32'h13); rd(8'h14, "R7");
    // R9 request-count reseed
    wr(8'h60, 32'd3); rd(8'h60, "R9");
    for (int k = 0; k < 3; k++) begin wr(8'h00, 32'h1); poll(GEN + 1, "R9"); end
    wr(8'h00, 32'h1); poll(SEED + 3, "R9"); read_words("R9");
    wr(8'h60, 32'd0);
    // R10 age-timer reseed
    seed_in = 32'h0BAD_F00D;
    wr(8'h64, 32'd40); rd(8'h64, "R10"); poll(60, "R10");
    wr(8'h00, 32'h1); poll(40, "R10"); wr(8'h64, 32'd0); poll(SEED + 2, "R10");
    // R11 lockup entry, refusal, recovery
    wr(8'h14, 32'h13); seed_in = 32'h0;
    wr(8'h00, 32'h2); poll(SEED + 2, "R11"); rd(8'h14, "R11");
    wr(8'h00, 32'h1); poll(3, "R11"); read_words("R11");
    seed_in = 32'h1357_9BDF;
    wr(8'h00, 32'h2); poll(SEED + 2, "R11");
    wr(8'h00, 32'h1); poll(GEN + 2, "R11"); read_words("R11");
    idle(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule